// File: doc/BRIEF.md
# Serial Flash Instruction-Table Sequencer

This block is a command engine for serial NOR flash devices that accept one, two or four data lines. Instead of a fixed transaction shape, it executes short microprograms kept in an on-chip table. Each table entry is a 16-bit instruction made of an opcode, a line-width code and an 8-bit operand. The table holds 16 sequences of eight instructions. Together these instructions describe the command byte, address bits, mode byte, idle cycles and the read or write data phase.

A host write port fills the table, the transmit buffer, the address register and the control registers. A write to the trigger register starts one sequence and gives the byte count for its data phase. The engine then drives chip select, a mode-0 serial clock at half the system clock, and up to four data lines. Read bytes are packed into a word-wide receive buffer that the host reads through a word index. When the engine is finished, a sticky completion flag is set, and an interrupt follows if it is enabled.

Host write map (hw_addr): bits 7:6 = 0 selects table word hw_addr[5:0]; 1 selects a control register by hw_addr[1:0] (0 trigger, 1 flag clear, 2 interrupt enable, 3 flash address); 2 selects transmit word hw_addr[3:0].

Top module: `flash_seq_engine`

## Requirements
- R1: Table word `seq*4+k` holds instruction 2k in bits 15:0 and instruction 2k+1 in bits 31:16. Each instruction has the opcode in bits 15:10, the line code in bits 9:8 and the operand in bits 7:0. A trigger (data bits 31:24 = sequence, low 4 bits used) runs from instruction 0 and ends at a STOP (opcode 0) or after the eighth instruction.
- R2: CMD (opcode 1) and MODE (opcode 4) send the operand byte MSB first over 8/w clocks. Line code 0, 1 and 2 give w = 1, 2 and 4 lines. One line uses io0. With several lines, the highest-numbered line carries the most significant bit of each group, on lines io[w-1:0].
- R3: ADDR (opcode 2) sends the low `operand` bits of the flash address register, MSB first, over operand/w clocks.
- R4: DUMMY (opcode 3) inserts `operand` serial clocks, 1 to at least 64, with every output enable low.
- R5: READ (opcode 7) takes the trigger's byte count (data bits 6:0) in bytes. Input is sampled while the serial clock is high: io1 for one line, io[1:0] for two, io[3:0] for four, MSB first. Byte n goes to bits 8*(n%4)+7:8*(n%4) of receive word n/4, and the unused upper bytes of a partial last word read as zero.
- R6: WRITE (opcode 8) sends the byte count in bytes from the transmit buffer. Byte n is taken from bits 8*(n%4)+7:8*(n%4) of transmit word n/4.
- R7: The serial clock idles low, and output data changes only while it is low. Chip select falls before the first clock and rises one serial clock after STOP. It then stays high for at least two serial clocks (4 system cycles) while busy is still set.
- R8: Busy is set from the cycle after an accepted trigger until the end of the chip-select gap. A trigger written while busy is ignored.
- R9: When busy falls, done_flag is set. Writing 1 to data bit 0 of the flag register clears it, and writing 0 has no effect. irq is high exactly while done_flag and the enable bit (data bit 0 of the enable register) are both set.
- R10: After reset, cs_n=1, sclk=0, io_oe=0, busy=0, done_flag=0 and irq=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_en | input | 1 | Host write strobe |
| hw_addr | input | 8 | Host write address (region in bits 7:6) |
| hw_data | input | 32 | Host write data |
| rx_idx | input | 4 | Receive buffer word index |
| rx_word | output | 32 | Receive buffer word at rx_idx |
| busy | output | 1 | Transaction in progress |
| done_flag | output | 1 | Sticky completion flag |
| irq | output | 1 | Completion interrupt |
| cs_n | output | 1 | Flash chip select, active low |
| sclk | output | 1 | Serial clock (mode 0) |
| io_out | output | 4 | Data line output values |
| io_oe | output | 4 | Data line output enables |
| io_in | input | 4 | Data line input values |

## Verification
The hardest conditions to reach are those where a byte's bit groups line up with a particular clock count from chip-select fall. Examples are a partial last receive word after the same buffer held a longer read, and a sequence that has no STOP and must halt after its eighth instruction. The bench drives the input lines from a pattern keyed to the serial-clock count since chip select fell, and runs the long dual read before the short quad read. The expected receive words then follow from the clock positions alone. The unterminated sequence is followed in the table by a sentinel command, and the bench counts the exact number of clocks.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

    localparam logic [5:0] OP_STOP  = 6'd0;
    localparam logic [5:0] OP_CMD   = 6'd1;
    localparam logic [5:0] OP_ADDR  = 6'd2;
    localparam logic [5:0] OP_DUMMY = 6'd3;
    localparam logic [5:0] OP_MODE  = 6'd4;
    localparam logic [5:0] OP_READ  = 6'd7;
    localparam logic [5:0] OP_WRITE = 6'd8;

    typedef struct packed {
        logic [5:0] op;
        logic [1:0] pad;
        logic [7:0] arg;
    } instr_t;

    typedef enum logic [2:0] {ST_IDLE, ST_LOAD, ST_RUN, ST_HOLD, ST_GAP} state_e;
    typedef enum logic [1:0] {PH_OUT, PH_IDLE, PH_RD, PH_WR} phase_e;

    function automatic instr_t pick_instr(input logic [31:0] w, input logic odd);
        return odd ? w[31:16] : w[15:0];
    endfunction

    // log2 of the number of lines; code 3 falls back to a single line
    function automatic logic [1:0] pad_shift(input logic [1:0] pad);
        return (pad == 2'd3) ? 2'd0 : pad;
    endfunction

    function automatic logic [7:0] clocks_per_byte(input logic [1:0] sh);
        return 8'd8 >> sh;
    endfunction

    function automatic logic [3:0] lane_mask(input logic [1:0] sh);
        case (sh)
            2'd0:    return 4'b0001;
            2'd1:    return 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic [3:0] drive_bits(input logic [31:0] sr, input logic [1:0] sh);
        case (sh)
            2'd0:    return {3'b000, sr[31]};
            2'd1:    return {2'b00, sr[31:30]};
            default: return sr[31:28];
        endcase
    endfunction

    function automatic logic [3:0] take_bits(input logic [3:0] pins, input logic [1:0] sh);
        case (sh)
            2'd0:    return {3'b000, pins[1]};
            2'd1:    return {2'b00, pins[1:0]};
            default: return pins;
        endcase
    endfunction

endpackage

// File: rtl/fseq_wordmem.sv
module fseq_wordmem #(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [31:0]   wdata,
    input  logic [AW-1:0] raddr,
    output logic [31:0]   rdata
);
    logic [31:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/fseq_rxpack.sv
module fseq_rxpack #(
    parameter int WORDS = 16,
    parameter int AW    = $clog2(WORDS),
    parameter int BW    = AW + 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [BW-1:0] bidx,
    input  logic [7:0]    bval,
    input  logic [AW-1:0] ridx,
    output logic [31:0]   rword
);
    logic [31:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
        end else if (we) begin
            // lane 0 opens a fresh word, so a short tail reads back zero-filled
            if (bidx[1:0] == 2'd0) mem[bidx[BW-1:2]] <= {24'b0, bval};
            else                   mem[bidx[BW-1:2]][8*bidx[1:0] +: 8] <= bval;
        end
    end

    assign rword = mem[ridx];
endmodule

// File: rtl/flash_seq_engine.sv
module flash_seq_engine
    import fseq_pkg::*;
#(
    parameter int SEQS      = 16,
    parameter int SEQ_LEN   = 8,
    parameter int BUF_WORDS = 16,
    parameter int GAP_SCLK  = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         hw_en,
    input  logic [7:0]                   hw_addr,
    input  logic [31:0]                  hw_data,
    input  logic [$clog2(BUF_WORDS)-1:0] rx_idx,
    output logic [31:0]                  rx_word,
    output logic                         busy,
    output logic                         done_flag,
    output logic                         irq,
    output logic                         cs_n,
    output logic                         sclk,
    output logic [3:0]                   io_out,
    output logic [3:0]                   io_oe,
    input  logic [3:0]                   io_in
);
    localparam int TBL_WORDS = SEQS * SEQ_LEN / 2;
    localparam int TBL_AW    = $clog2(TBL_WORDS);
    localparam int SEQ_W     = $clog2(SEQS);
    localparam int PC_W      = $clog2(SEQ_LEN) + 1;
    localparam int BUF_AW    = $clog2(BUF_WORDS);
    localparam int BIDX_W    = BUF_AW + 2;
    localparam int LEN_W     = BIDX_W + 1;
    localparam int GAP_CYC   = 2 * GAP_SCLK;

    state_e              state_q;
    phase_e              kind_q;
    logic                cs_n_q, sclk_q, ph_q, done_q, ie_q;
    logic [31:0]         sr_q, addr_q;
    logic [7:0]          rb_q, cnt_q;
    logic [1:0]          sh_q;
    logic [PC_W-1:0]     pc_q;
    logic [SEQ_W-1:0]    seq_q;
    logic [LEN_W-1:0]    len_q;
    logic [BIDX_W-1:0]   byte_idx_q;

    // host decode
    logic tbl_we, ctl_we, tx_we, trig;
    assign tbl_we = hw_en && (hw_addr[7:6] == 2'd0);
    assign ctl_we = hw_en && (hw_addr[7:6] == 2'd1);
    assign tx_we  = hw_en && (hw_addr[7:6] == 2'd2);
    assign trig   = ctl_we && (hw_addr[1:0] == 2'd0) && (state_q == ST_IDLE);

    // instruction table
    logic [31:0] tbl_rdata;
    instr_t      ins;
    fseq_wordmem #(.DEPTH(TBL_WORDS)) u_table (
        .clk(clk), .rst(rst), .we(tbl_we), .waddr(hw_addr[TBL_AW-1:0]),
        .wdata(hw_data), .raddr({seq_q, pc_q[PC_W-2:1]}), .rdata(tbl_rdata)
    );
    assign ins = pick_instr(tbl_rdata, pc_q[0]);

    // transmit buffer: next byte to send
    logic [BIDX_W-1:0] tx_ptr;
    logic [31:0]       tx_rdata;
    logic [7:0]        tx_byte;
    assign tx_ptr = (state_q == ST_LOAD) ? '0 : BIDX_W'(byte_idx_q + 1'b1);
    fseq_wordmem #(.DEPTH(BUF_WORDS)) u_txbuf (
        .clk(clk), .rst(rst), .we(tx_we), .waddr(hw_addr[BUF_AW-1:0]),
        .wdata(hw_data), .raddr(tx_ptr[BIDX_W-1:2]), .rdata(tx_rdata)
    );
    assign tx_byte = tx_rdata[8*tx_ptr[1:0] +: 8];

    // receive path
    logic [2:0] lanes;
    logic [7:0] rd_next;
    logic       rx_we;
    assign lanes   = 3'd1 << sh_q;
    assign rd_next = (rb_q << lanes) | {4'b0, take_bits(io_in, sh_q)};
    assign rx_we   = (state_q == ST_RUN) && ph_q && (kind_q == PH_RD) && (cnt_q == 8'd1);
    fseq_rxpack #(.WORDS(BUF_WORDS)) u_rxbuf (
        .clk(clk), .rst(rst), .we(rx_we), .bidx(byte_idx_q), .bval(rd_next),
        .ridx(rx_idx), .rword(rx_word)
    );

    // decode helpers for the instruction being loaded
    logic [1:0] ins_sh;
    logic [7:0] ins_cpb, ins_addr_clk;
    logic       more_bytes;
    assign ins_sh       = pad_shift(ins.pad);
    assign ins_cpb      = clocks_per_byte(ins_sh);
    assign ins_addr_clk = ins.arg >> ins_sh;
    assign more_bytes   = (({1'b0, byte_idx_q} + LEN_W'(1)) < len_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;  kind_q <= PH_OUT;
            cs_n_q <= 1'b1;      sclk_q <= 1'b0;   ph_q <= 1'b0;
            done_q <= 1'b0;      ie_q <= 1'b0;
            sr_q <= '0;          addr_q <= '0;     rb_q <= '0;
            cnt_q <= '0;         sh_q <= '0;       pc_q <= '0;
            seq_q <= '0;         len_q <= '0;      byte_idx_q <= '0;
        end else begin
            if (ctl_we && hw_addr[1:0] == 2'd1 && hw_data[0]) done_q <= 1'b0;
            if (ctl_we && hw_addr[1:0] == 2'd2) ie_q <= hw_data[0];
            if (ctl_we && hw_addr[1:0] == 2'd3) addr_q <= hw_data;
            case (state_q)
                ST_IDLE: if (trig) begin
                    seq_q   <= hw_data[24 +: SEQ_W];
                    len_q   <= hw_data[LEN_W-1:0];
                    pc_q    <= '0;
                    cs_n_q  <= 1'b0;
                    state_q <= ST_LOAD;
                end
                ST_LOAD: begin
                    byte_idx_q <= '0;
                    rb_q       <= '0;
                    sh_q       <= ins_sh;
                    if (pc_q == PC_W'(SEQ_LEN) || ins.op == OP_STOP) begin
                        cnt_q   <= 8'd2;
                        state_q <= ST_HOLD;
                    end else begin
                        case (ins.op)
                            OP_CMD, OP_MODE: begin
                                sr_q <= {ins.arg, 24'b0}; cnt_q <= ins_cpb;
                                kind_q <= PH_OUT; state_q <= ST_RUN;
                            end
                            OP_ADDR: if (ins_addr_clk != 8'd0) begin
                                sr_q <= addr_q << (7'd32 - {1'b0, ins.arg[5:0]});
                                cnt_q <= ins_addr_clk; kind_q <= PH_OUT; state_q <= ST_RUN;
                            end else pc_q <= pc_q + 1'b1;
                            OP_DUMMY: if (ins.arg != 8'd0) begin
                                cnt_q <= ins.arg; kind_q <= PH_IDLE; state_q <= ST_RUN;
                            end else pc_q <= pc_q + 1'b1;
                            OP_READ: if (len_q != '0) begin
                                cnt_q <= ins_cpb; kind_q <= PH_RD; state_q <= ST_RUN;
                            end else pc_q <= pc_q + 1'b1;
                            OP_WRITE: if (len_q != '0) begin
                                sr_q <= {tx_byte, 24'b0}; cnt_q <= ins_cpb;
                                kind_q <= PH_WR; state_q <= ST_RUN;
                            end else pc_q <= pc_q + 1'b1;
                            default: pc_q <= pc_q + 1'b1;
                        endcase
                    end
                end
                ST_RUN: begin
                    if (!ph_q) begin
                        sclk_q <= 1'b1;
                        ph_q   <= 1'b1;
                    end else begin
                        sclk_q <= 1'b0;
                        ph_q   <= 1'b0;
                        sr_q   <= sr_q << lanes;
                        rb_q   <= rd_next;
                        if (cnt_q != 8'd1) begin
                            cnt_q <= cnt_q - 8'd1;
                        end else if ((kind_q == PH_RD || kind_q == PH_WR) && more_bytes) begin
                            byte_idx_q <= byte_idx_q + 1'b1;
                            cnt_q      <= clocks_per_byte(sh_q);
                            if (kind_q == PH_WR) sr_q <= {tx_byte, 24'b0};
                        end else begin
                            pc_q    <= pc_q + 1'b1;
                            state_q <= ST_LOAD;
                        end
                    end
                end
                ST_HOLD: begin
                    if (cnt_q == 8'd1) begin
                        cs_n_q  <= 1'b1;
                        cnt_q   <= 8'(GAP_CYC);
                        state_q <= ST_GAP;
                    end else cnt_q <= cnt_q - 8'd1;
                end
                ST_GAP: begin
                    if (cnt_q == 8'd1) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end else cnt_q <= cnt_q - 8'd1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    logic driving;
    assign driving   = (state_q == ST_RUN) && (kind_q == PH_OUT || kind_q == PH_WR);
    assign io_oe     = driving ? lane_mask(sh_q) : 4'b0;
    assign io_out    = driving ? drive_bits(sr_q, sh_q) : 4'b0;
    assign cs_n      = cs_n_q;
    assign sclk      = sclk_q;
    assign busy      = (state_q != ST_IDLE);
    assign done_flag = done_q;
    assign irq       = done_q && ie_q;
endmodule

// File: rtl/fseq_chk.sv
module fseq_chk (
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       sclk,
    input logic [3:0] io_oe,
    input logic       busy,
    input logic       done_flag,
    input logic       irq
);
    p_quiet_when_deselected_r7: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> (!sclk && io_oe == 4'b0));

    p_select_inside_busy_r8: assert property (@(posedge clk) disable iff (rst)
        !cs_n |-> busy);

    p_gap_after_release_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |=> (cs_n && busy));

    p_sclk_high_one_cycle_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk) |=> $fell(sclk));

    p_flag_at_end_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(done_flag) |-> $fell(busy));

    p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (rst)
        irq |-> done_flag);
endmodule

bind flash_seq_engine fseq_chk u_chk (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .io_oe(io_oe),
    .busy(busy), .done_flag(done_flag), .irq(irq)
);

// File: tb/flash_seq_engine_tb.sv
module flash_seq_engine_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        hw_en = 1'b0;
    logic [7:0]  hw_addr = '0;
    logic [31:0] hw_data = '0;
    logic [3:0]  rx_idx = '0;
    logic [31:0] rx_word;
    logic        busy, done_flag, irq, cs_n, sclk;
    logic [3:0]  io_out, io_oe;
    logic [3:0]  io_in = '0;

    int ntot = 0;
    int nbad = 0;
    int gap;

    always #4 clk = ~clk;

    flash_seq_engine u_dut (
        .clk(clk), .rst(rst), .hw_en(hw_en), .hw_addr(hw_addr), .hw_data(hw_data),
        .rx_idx(rx_idx), .rx_word(rx_word), .busy(busy), .done_flag(done_flag),
        .irq(irq), .cs_n(cs_n), .sclk(sclk), .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
    );

    // flash-side model: capture on rising sclk, present pattern per clock index
    logic [3:0] cap_io [256];
    logic [3:0] cap_oe [256];
    int ncap = 0;
    int kclk = 0;

    function automatic logic [3:0] fpat(input int k);
        return 4'((k * 5 + 3) & 15);
    endfunction

    always @(negedge cs_n) begin
        ncap  = 0;
        kclk  = 0;
        io_in = fpat(0);
    end
    always @(posedge sclk) begin
        if (ncap < 256) begin
            cap_io[ncap] = io_out;
            cap_oe[ncap] = io_oe;
        end
        ncap++;
    end
    always @(negedge sclk) begin
        kclk++;
        io_in = fpat(kclk);
    end

    function automatic logic [15:0] ins(input int op, input int pad, input int arg);
        return {6'(op), 2'(pad), 8'(arg)};
    endfunction

    function automatic logic [3:0] wmask(input int w);
        return 4'((1 << w) - 1);
    endfunction

    function automatic logic [7:0] exp_rd(input int k0, input int w, input int b);
        logic [7:0] v;
        int per;
        v = '0;
        per = 8 / w;
        for (int j = 0; j < per; j++) begin
            logic [3:0] p;
            p = fpat(k0 + b * per + j);
            case (w)
                1:       v = {v[6:0], p[1]};
                2:       v = {v[5:0], p[1:0]};
                default: v = {v[3:0], p};
            endcase
        end
        return v;
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        ntot++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic chk_out(input int c0, input logic [7:0] byt, input int w, input string tag);
        for (int j = 0; j < 8 / w; j++) begin
            logic [3:0] e;
            e = 4'((byt >> (8 - w * (j + 1))) & ((1 << w) - 1));
            chk((cap_io[c0+j] & wmask(w)) == e, tag, 32'(cap_io[c0+j] & wmask(w)), 32'(e));
            chk(cap_oe[c0+j] == wmask(w), tag, 32'(cap_oe[c0+j]), 32'(wmask(w)));
        end
    endtask

    task automatic hwr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        hw_en = 1'b1; hw_addr = a; hw_data = d;
        @(negedge clk);
        hw_en = 1'b0;
    endtask

    task automatic wait_idle();
        gap = 0;
        while (busy) begin
            if (cs_n) gap++;
            @(negedge clk);
        end
    endtask

    task automatic run(input int seq, input int len);
        hwr(8'h40, {8'(seq), 17'b0, 7'(len)});
        wait_idle();
        chk(gap >= 4, "R7 cs gap", 32'(gap), 32'd4);
    endtask

    task automatic rdrx(input int idx, output logic [31:0] v);
        rx_idx = 4'(idx);
        #1;
        v = rx_word;
    endtask

    task automatic load_table();
        hwr(8'd0,  {16'h0000, ins(1, 0, 8'h9F)});
        hwr(8'd12, {ins(2, 0, 24), ins(1, 0, 8'h6B)});
        hwr(8'd13, {ins(7, 2, 0), ins(3, 2, 8)});
        hwr(8'd16, {ins(7, 1, 0), ins(1, 0, 8'h3B)});
        hwr(8'd20, {ins(4, 2, 8'hA5), ins(1, 0, 8'h32)});
        hwr(8'd21, {16'h0000, ins(8, 2, 0)});
        hwr(8'd24, {ins(7, 0, 0), ins(1, 0, 8'h03)});
        hwr(8'd28, {ins(3, 0, 64), ins(1, 0, 8'h05)});
        for (int i = 0; i < 4; i++)
            hwr(8'(32 + i), {ins(1, 0, 16 + 2*i + 1), ins(1, 0, 16 + 2*i)});
        hwr(8'd36, {16'h0000, ins(1, 0, 8'hEE)});
    endtask

    task automatic t_reset();
        chk(cs_n == 1'b1 && sclk == 1'b0, "R10 cs/sclk", {30'b0, cs_n, sclk}, 32'h2);
        chk(io_oe == 4'b0, "R10 oe", 32'(io_oe), 0);
        chk(!busy && !done_flag && !irq, "R10 busy/flag/irq", {29'b0, busy, done_flag, irq}, 0);
    endtask

    task automatic t_cmd_single();
        run(0, 0);
        chk(ncap == 8, "R1 clocks to STOP", 32'(ncap), 8);
        chk_out(0, 8'h9F, 1, "R2 single-line cmd");
        chk(done_flag == 1'b1, "R9 flag set", 32'(done_flag), 1);
        chk(irq == 1'b0, "R9 irq masked", 32'(irq), 0);
    endtask

    task automatic t_dual_read();
        logic [31:0] v;
        run(4, 8);
        chk(ncap == 40, "R5 dual read clocks", 32'(ncap), 40);
        for (int wd = 0; wd < 2; wd++) begin
            logic [31:0] e;
            e = {exp_rd(8, 2, 4*wd+3), exp_rd(8, 2, 4*wd+2), exp_rd(8, 2, 4*wd+1), exp_rd(8, 2, 4*wd)};
            rdrx(wd, v);
            chk(v == e, "R5 dual read word", v, e);
        end
    endtask

    task automatic t_quad_read();
        logic [31:0] v, e;
        int nz;
        hwr(8'h43, 32'hAB123456);
        run(3, 6);
        chk(ncap == 52, "R1 quad read clocks", 32'(ncap), 52);
        chk_out(0,  8'h6B, 1, "R2 cmd");
        chk_out(8,  8'h12, 1, "R3 addr byte2");
        chk_out(16, 8'h34, 1, "R3 addr byte1");
        chk_out(24, 8'h56, 1, "R3 addr byte0");
        nz = 0;
        for (int i = 32; i < 40; i++) if (cap_oe[i] != 4'b0) nz++;
        chk(nz == 0, "R4 dummy lines released", 32'(nz), 0);
        e = {exp_rd(40, 4, 3), exp_rd(40, 4, 2), exp_rd(40, 4, 1), exp_rd(40, 4, 0)};
        rdrx(0, v);
        chk(v == e, "R5 quad word0", v, e);
        e = {16'h0000, exp_rd(40, 4, 5), exp_rd(40, 4, 4)};
        rdrx(1, v);
        chk(v == e, "R5 partial word zero-filled", v, e);
    endtask

    task automatic t_single_read();
        logic [31:0] v, e;
        run(6, 2);
        chk(ncap == 24, "R5 single read clocks", 32'(ncap), 24);
        e = {16'h0000, exp_rd(8, 1, 1), exp_rd(8, 1, 0)};
        rdrx(0, v);
        chk(v == e, "R5 single-line read on io1", v, e);
    endtask

    task automatic t_write();
        logic [7:0] exp_b [5];
        exp_b = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
        hwr(8'h80, 32'h44332211);
        hwr(8'h81, 32'hDEADBE55);
        run(5, 5);
        chk(ncap == 20, "R6 write clocks", 32'(ncap), 20);
        chk_out(8, 8'hA5, 4, "R2 quad mode byte");
        for (int b = 0; b < 5; b++) chk_out(10 + 2*b, exp_b[b], 4, "R6 write byte order");
    endtask

    task automatic t_dummy64();
        int nz;
        run(7, 0);
        chk(ncap == 72, "R4 64 dummy clocks", 32'(ncap), 72);
        nz = 0;
        for (int i = 8; i < 72; i++) if (cap_oe[i] != 4'b0) nz++;
        chk(nz == 0, "R4 no drive in dummy", 32'(nz), 0);
    endtask

    task automatic t_eight_no_stop();
        run(8, 0);
        chk(ncap == 64, "R1 halt after eighth", 32'(ncap), 64);
        chk_out(8,  8'h11, 1, "R1 odd half order");
        chk_out(56, 8'h17, 1, "R1 last instruction");
    endtask

    task automatic t_busy_ignore();
        hwr(8'h40, 32'h00000000);
        chk(busy == 1'b1, "R8 busy after trigger", 32'(busy), 1);
        hwr(8'h40, 32'h07000000);
        wait_idle();
        chk(ncap == 8, "R8 second trigger ignored", 32'(ncap), 8);
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && cs_n == 1'b1, "R8 stays idle", {30'b0, busy, cs_n}, 32'h1);
    endtask

    task automatic t_irq();
        hwr(8'h41, 32'h1);
        chk(done_flag == 1'b0, "R9 clear", 32'(done_flag), 0);
        hwr(8'h42, 32'h1);
        run(0, 0);
        chk(irq == 1'b1 && done_flag == 1'b1, "R9 irq raised", {30'b0, irq, done_flag}, 32'h3);
        hwr(8'h41, 32'h0);
        chk(done_flag == 1'b1, "R9 write 0 keeps flag", 32'(done_flag), 1);
        hwr(8'h41, 32'h1);
        chk(done_flag == 1'b0 && irq == 1'b0, "R9 w1c drops irq", {30'b0, irq, done_flag}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        ntot++;
        nbad++;
        $display("FAIL watchdog act=hung exp=finished");
        $display("test done: total=%0d bad=%0d", ntot, nbad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        load_table();
        t_cmd_single();
        t_dual_read();
        t_quad_read();
        t_single_read();
        t_write();
        t_dummy64();
        t_eight_no_stop();
        t_busy_ignore();
        t_irq();
        $display("test done: total=%0d bad=%0d", ntot, nbad);
        $finish;
    end
endmodule